// File: doc/BRIEF.md
# Debug Pin Acknowledge Handshake

This block is the target-side completion handshake for a single-wire, bidirectional, open-drain debug pin. A command decoder placed ahead of it reports command events: handshake on, handshake off, read issued, write data fully shifted in, and internal bus cycle finished. When a command completes and the handshake is switched on, the block tells the host by pulling the shared pin low for a fixed number of debug clock cycles. It then drives the pin high for one cycle to speed up the rising edge and releases the pin.

The block also watches the pin for a long low pulse from the host, which is a sync request. A detected sync produces a one-cycle flag and cancels any acknowledge that is pending but has not started. The host may pull the pin low while the target's own pulse is running. That overlap is allowed: the pulse runs to its end, and low samples taken while the target drives the pin are not counted toward a sync.

Top module: `dbg_ack_handshake`

## Requirements
- R1: After reset, the pin drivers are off (all three pin controls low), the sync flag is low, and the handshake is off. While it is off, completed commands produce no pulse.
- R2: A handshake-on event turns the handshake on and is itself acknowledged. If the event is sampled at clock edge E, the pulse's first low cycle is the cycle after edge E+1.
- R3: An acknowledge pulse has three parts. First, exactly 16 cycles with driveLow and driveEn high. Next, exactly one cycle with driveHigh and driveEn high. Then the pin is released, with all three controls low.
- R4: A read is acknowledged only after a bus-cycle-done event that follows the read event. The pulse starts with the same two-edge latency as in R2.
- R5: A write is acknowledged once both the data-received event and a bus-cycle-done event have arrived, in either order, with no read outstanding. Neither event alone produces a pulse.
- R6: A handshake-off event produces no pulse and turns the handshake off, so later completions are not acknowledged. A pulse that has already started when it arrives still runs to its full length.
- R7: At most one acknowledge can be pending. Any number of completions during a running pulse yield exactly one further pulse, which starts after exactly one released cycle.
- R8: A run of 128 consecutive low pin samples, taken while the block is not driving, raises syncDetected for exactly one cycle, in the cycle after the 128th sample. A run of 127 samples does not raise it.
- R9: A sync detection clears a pending acknowledge that has not yet started, so no pulse follows.
- R10: Host low samples taken while the block drives the pin are not counted toward sync, and a colliding host low does not shorten or stop the pulse.
- R11: driveLow and driveHigh are never high together. driveEn is high exactly when one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enableCmd | input | 1 | One-cycle handshake-on event |
| disableCmd | input | 1 | One-cycle handshake-off event (has priority over enableCmd) |
| readCmd | input | 1 | One-cycle event: a read command was issued |
| writeDataDone | input | 1 | One-cycle event: all write data has been received |
| busCycleDone | input | 1 | One-cycle event: the internal bus cycle finished |
| pinIn | input | 1 | Sampled level of the debug pin |
| driveLow | output | 1 | Pull the pin low |
| driveHigh | output | 1 | Drive the pin high (speedup step) |
| driveEn | output | 1 | Output enable for the pin driver |
| syncDetected | output | 1 | One-cycle flag: a host sync request was seen |

## Verification
The hardest case to reach is a sync that aborts a pending acknowledge. A pending acknowledge waits only one cycle before its pulse starts, so the sync must be detected on exactly the edge where the pulse would otherwise begin. To get there, the bench holds the pin low from a known negative edge and counts sampling edges. It presents the bus-cycle-done of an outstanding read on the 127th edge, so the 128th edge sees the new pending acknowledge and the sync threshold together. The collision case is also driven deliberately: the host holds the pin low across an entire pulse for longer than the threshold. A sync flag is then expected only if driven cycles were wrongly counted.

// File: rtl/ack_pkg.sv
package ack_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } ackState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startLow;
    logic startHigh;
    logic releasePin;
  } ackStrobe_t;

endpackage

// File: rtl/ack_datapath.sv
module ack_datapath
  import ack_pkg::*;
#(
  parameter int LOW_LEN  = 16,
  parameter int SYNC_LEN = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  ackStrobe_t strobe,
  input  logic       pinIn,
  output logic       driveLow,
  output logic       driveHigh,
  output logic       driveEn,
  output logic       lowDone,
  output logic       syncHit,
  output logic       syncDetected
);

  localparam int LOW_W  = (LOW_LEN > 1) ? $clog2(LOW_LEN) : 1;
  localparam int SYNC_W = $clog2(SYNC_LEN + 1);
  localparam logic [LOW_W-1:0]  LOW_LAST  = LOW_W'(LOW_LEN - 1);
  localparam logic [SYNC_W-1:0] SYNC_LAST = SYNC_W'(SYNC_LEN - 1);
  localparam logic [SYNC_W-1:0] SYNC_TOP  = SYNC_W'(SYNC_LEN);

  logic [LOW_W-1:0]  lowCnt;
  logic [SYNC_W-1:0] syncCnt;
  logic              hostLowSample;

  // pin drivers and the low-phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveLow  <= 1'b0;
      driveHigh <= 1'b0;
      driveEn   <= 1'b0;
      lowCnt    <= '0;
    end else if (strobe.startLow) begin
      driveLow  <= 1'b1;
      driveHigh <= 1'b0;
      driveEn   <= 1'b1;
      lowCnt    <= '0;
    end else if (strobe.startHigh) begin
      driveLow  <= 1'b0;
      driveHigh <= 1'b1;
      driveEn   <= 1'b1;
      lowCnt    <= '0;
    end else if (strobe.releasePin) begin
      driveLow  <= 1'b0;
      driveHigh <= 1'b0;
      driveEn   <= 1'b0;
      lowCnt    <= '0;
    end else if (driveLow) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  assign lowDone = driveLow && (lowCnt == LOW_LAST);

  // sync watcher: only counts while the pin is not driven by this block
  assign hostLowSample = !pinIn && !driveEn;
  assign syncHit       = hostLowSample && (syncCnt == SYNC_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncCnt      <= '0;
      syncDetected <= 1'b0;
    end else begin
      syncDetected <= syncHit;
      if (!hostLowSample) begin
        syncCnt <= '0;
      end else if (syncCnt != SYNC_TOP) begin
        syncCnt <= syncCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ack_ctrl.sv
module ack_ctrl
  import ack_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enableCmd,
  input  logic       disableCmd,
  input  logic       readCmd,
  input  logic       writeDataDone,
  input  logic       busCycleDone,
  input  logic       lowDone,
  input  logic       syncHit,
  output ackStrobe_t strobe,
  output logic       ackOn
);

  ackState_t state, stateNext;
  logic rdWait, wrData, wrBus, pending;
  logic rdComplete, wrComplete, ackReq, startNow;
  logic wrDataSeen, wrBusSeen;

  // completion decode
  assign rdComplete = rdWait && busCycleDone;
  assign wrDataSeen = wrData || writeDataDone;
  assign wrBusSeen  = wrBus || (busCycleDone && !rdWait);
  assign wrComplete = wrDataSeen && wrBusSeen;

  assign ackReq = !disableCmd &&
                  (enableCmd || (ackOn && (rdComplete || wrComplete)));

  assign startNow = (state == ST_IDLE) && pending && !syncHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackOn  <= 1'b0;
      rdWait <= 1'b0;
      wrData <= 1'b0;
      wrBus  <= 1'b0;
    end else begin
      if (disableCmd)     ackOn <= 1'b0;
      else if (enableCmd) ackOn <= 1'b1;

      if (readCmd)         rdWait <= 1'b1;
      else if (rdComplete) rdWait <= 1'b0;

      if (wrComplete) begin
        wrData <= 1'b0;
        wrBus  <= 1'b0;
      end else begin
        wrData <= wrDataSeen;
        wrBus  <= wrBusSeen;
      end
    end
  end

  // single pending slot: sync abort wins, then new request, then consume
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pending <= 1'b0;
    else if (syncHit)   pending <= 1'b0;
    else if (ackReq)    pending <= 1'b1;
    else if (startNow)  pending <= 1'b0;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (startNow) begin
        strobe.startLow = 1'b1;
        stateNext       = ST_LOW;
      end
      ST_LOW: if (lowDone) begin
        strobe.startHigh = 1'b1;
        stateNext        = ST_HIGH;
      end
      ST_HIGH: begin
        strobe.releasePin = 1'b1;
        stateNext         = ST_IDLE;
      end
      default: begin
        strobe.releasePin = 1'b1;
        stateNext         = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/dbg_ack_handshake.sv
module dbg_ack_handshake
  import ack_pkg::*;
#(
  parameter int LOW_LEN  = 16,
  parameter int SYNC_LEN = 128
) (
  input  logic clk,
  input  logic rstN,
  input  logic enableCmd,
  input  logic disableCmd,
  input  logic readCmd,
  input  logic writeDataDone,
  input  logic busCycleDone,
  input  logic pinIn,
  output logic driveLow,
  output logic driveHigh,
  output logic driveEn,
  output logic syncDetected
);

  ackStrobe_t strobe;
  logic lowDone, syncHit, ackOn;

  ack_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .enableCmd(enableCmd), .disableCmd(disableCmd),
    .readCmd(readCmd), .writeDataDone(writeDataDone),
    .busCycleDone(busCycleDone),
    .lowDone(lowDone), .syncHit(syncHit),
    .strobe(strobe), .ackOn(ackOn)
  );

  ack_datapath #(.LOW_LEN(LOW_LEN), .SYNC_LEN(SYNC_LEN)) dp_i (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .pinIn(pinIn),
    .driveLow(driveLow), .driveHigh(driveHigh), .driveEn(driveEn),
    .lowDone(lowDone), .syncHit(syncHit), .syncDetected(syncDetected)
  );

endmodule

// File: rtl/dbg_ack_handshake_chk.sv
module dbg_ack_handshake_chk #(
  parameter int LOW_LEN = 16
) (
  input logic clk,
  input logic rstN,
  input logic driveLow,
  input logic driveHigh,
  input logic driveEn,
  input logic syncDetected
);

  localparam int RUN_W = $clog2(LOW_LEN + 2);
  logic [RUN_W-1:0] lowRun;

  // length of the current low phase, held through the speedup cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          lowRun <= '0;
    else if (driveLow)  lowRun <= lowRun + 1'b1;
    else if (!driveHigh) lowRun <= '0;
  end

  assert_drive_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(driveLow && driveHigh));

  assert_enable_match_R11: assert property (@(posedge clk) disable iff (!rstN)
    driveEn == (driveLow || driveHigh));

  assert_speedup_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(driveLow) |-> driveHigh);

  assert_release_after_speedup_R3: assert property (@(posedge clk) disable iff (!rstN)
    driveHigh |=> !driveEn);

  assert_low_length_R3: assert property (@(posedge clk) disable iff (!rstN)
    driveHigh |-> (lowRun == RUN_W'(LOW_LEN)));

  assert_sync_one_cycle_R8: assert property (@(posedge clk) disable iff (!rstN)
    syncDetected |=> !syncDetected);

endmodule

bind dbg_ack_handshake dbg_ack_handshake_chk #(.LOW_LEN(LOW_LEN)) chk_i (
  .clk(clk), .rstN(rstN),
  .driveLow(driveLow), .driveHigh(driveHigh), .driveEn(driveEn),
  .syncDetected(syncDetected)
);

// File: tb/dbg_ack_handshake_tb_top.sv
`timescale 1ns/1ps
module dbg_ack_handshake_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enableCmd = 0, disableCmd = 0, readCmd = 0, writeDataDone = 0, busCycleDone = 0;
  logic hostLow = 0;
  logic pinIn;
  logic driveLow, driveHigh, driveEn, syncDetected;
  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  // open-drain pin model
  assign pinIn = !((driveEn && driveLow) || hostLow);

  dbg_ack_handshake dut_i (
    .clk(clk), .rstN(rstN),
    .enableCmd(enableCmd), .disableCmd(disableCmd),
    .readCmd(readCmd), .writeDataDone(writeDataDone),
    .busCycleDone(busCycleDone), .pinIn(pinIn),
    .driveLow(driveLow), .driveHigh(driveHigh), .driveEn(driveEn),
    .syncDetected(syncDetected)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // 0 enable, 1 disable, 2 read, 3 write data, 4 bus done; one cycle wide
  task automatic fire(input int which);
    case (which)
      0: enableCmd = 1;
      1: disableCmd = 1;
      2: readCmd = 1;
      3: writeDataDone = 1;
      default: busCycleDone = 1;
    endcase
    @(negedge clk);
    enableCmd = 0; disableCmd = 0; readCmd = 0; writeDataDone = 0; busCycleDone = 0;
  endtask

  task automatic expectPulse(input string tag);
    int lows = 0;
    @(negedge clk);
    check(driveLow && driveEn, {tag, " pulse start latency"}, int'(driveLow), 1);
    while (driveLow && lows < 40) begin
      lows++;
      @(negedge clk);
    end
    check(lows == 16, {tag, " R3 low cycles"}, lows, 16);
    check(driveHigh && driveEn && !driveLow, {tag, " R3 speedup"}, int'(driveHigh), 1);
    @(negedge clk);
    check(!driveEn && !driveLow && !driveHigh, {tag, " R3 release"}, int'(driveEn), 0);
  endtask

  task automatic expectNone(input int n, input string tag);
    int bad = 0;
    repeat (n) begin
      @(negedge clk);
      if (driveEn) bad++;
    end
    check(bad == 0, {tag, " no pulse"}, bad, 0);
  endtask

  task automatic testReset();
    check(!driveEn && !driveLow && !driveHigh, "R1 drivers off in reset", int'(driveEn), 0);
    check(!syncDetected, "R1 sync flag low in reset", int'(syncDetected), 0);
    rstN = 1;
    @(negedge clk);
    fire(2); fire(4);
    expectNone(30, "R1 handshake off after reset");
    fire(3); fire(4);
    expectNone(30, "R1 write while off");
  endtask

  task automatic testEnable();
    fire(0);
    expectPulse("R2 enable ack");
  endtask

  task automatic testRead();
    fire(2);
    expectNone(5, "R4 before bus done");
    fire(4);
    expectPulse("R4 read ack");
  endtask

  task automatic testWrite();
    fire(3);
    expectNone(5, "R5 data only");
    fire(4);
    expectPulse("R5 data then bus");
    fire(4);
    expectNone(5, "R5 bus only");
    fire(3);
    expectPulse("R5 bus then data");
  endtask

  task automatic testQueue();
    int waitN = 0;
    fire(2); fire(4);
    fire(2); fire(4); fire(2); fire(4);
    while (!driveHigh && waitN < 40) begin
      @(negedge clk);
      waitN++;
    end
    check(driveHigh, "R7 first pulse reached speedup", int'(driveHigh), 1);
    @(negedge clk);
    check(!driveEn, "R7 one released cycle between pulses", int'(driveEn), 0);
    expectPulse("R7 queued pulse");
    expectNone(30, "R7 only one queued");
  endtask

  task automatic testDisable();
    int lows = 0;
    int highs = 0;
    fire(2); fire(4);
    fire(1);
    repeat (25) begin
      if (driveLow) lows++;
      if (driveHigh) highs++;
      @(negedge clk);
    end
    check(lows == 16, "R6 in-flight pulse completes low", lows, 16);
    check(highs == 1, "R6 in-flight pulse speedup", highs, 1);
    fire(2); fire(4);
    expectNone(30, "R6 after disable");
    fire(1);
    expectNone(20, "R6 disable itself");
    fire(0);
    expectPulse("R6 re-enable");
  endtask

  task automatic testSyncThreshold();
    int seen = 0;
    hostLow = 1;
    for (int k = 1; k <= 127; k++) begin
      @(negedge clk);
      if (syncDetected) seen++;
    end
    hostLow = 0;
    repeat (3) begin
      @(negedge clk);
      if (syncDetected) seen++;
    end
    check(seen == 0, "R8 127 low samples no sync", seen, 0);
    seen = 0;
    hostLow = 1;
    for (int k = 1; k <= 131; k++) begin
      @(negedge clk);
      if (k == 128) check(syncDetected, "R8 sync after 128 samples", int'(syncDetected), 1);
      else if (syncDetected) seen++;
    end
    hostLow = 0;
    @(negedge clk);
    check(seen == 0, "R8 sync flag one cycle only", seen, 0);
  endtask

  task automatic testSyncAbort();
    int bad = 0;
    fire(2);
    hostLow = 1;
    for (int k = 1; k <= 160; k++) begin
      @(negedge clk);
      if (k == 126) busCycleDone = 1;
      if (k == 127) busCycleDone = 0;
      if (k == 128) check(syncDetected, "R9 sync seen at abort edge", int'(syncDetected), 1);
      if (k == 135) hostLow = 0;
      if (driveEn) bad++;
    end
    check(bad == 0, "R9 pending ack aborted by sync", bad, 0);
  endtask

  task automatic testCollision();
    int lows = 0;
    int highs = 0;
    int syncs = 0;
    fire(2);
    busCycleDone = 1;
    hostLow = 1;
    for (int k = 1; k <= 130; k++) begin
      @(negedge clk);
      if (k == 1) busCycleDone = 0;
      if (driveLow) lows++;
      if (driveHigh) highs++;
      if (syncDetected) syncs++;
    end
    hostLow = 0;
    repeat (3) begin
      @(negedge clk);
      if (syncDetected) syncs++;
    end
    check(lows == 16, "R10 pulse low length under collision", lows, 16);
    check(highs == 1, "R10 speedup under collision", highs, 1);
    check(syncs == 0, "R10 driven cycles not counted for sync", syncs, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    testEnable();
    testRead();
    testWrite();
    testQueue();
    testDisable();
    testSyncThreshold();
    testSyncAbort();
    testCollision();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule